// File: doc/BRIEF.md
# Guest Event Exit Router

While a guest context runs, this block watches four classes of platform event: INIT, SIPI, NMI and external interrupt. For each one it decides whether the event forces an exit to the host monitor. When an exit is forced, the block raises a one-cycle exit strobe together with a 3-bit reason code. If the exit was caused by an external interrupt, it also pulses a clear of the guest interrupt-enable flag.

Two control bits decide whether an NMI or an external interrupt exits at all. INIT and SIPI always exit. A virtual-NMI mode forces every NMI to exit, and the block keeps a separate guest readiness flag for virtual NMIs that the monitor updates. With acknowledge-on-exit set, an external-interrupt exit first runs a request/acknowledge handshake with the interrupt controller. The exit waits for that handshake, and the vector returned on acknowledge is captured and marked valid.

The block makes one exit per guest run. The host lowers `guest_active_i` to leave guest context and raises it again on the next entry.

Top module: `guest_exit_router`

## Requirements
- R1: After reset, `exit_o`, `inta_req_o`, `if_clear_o` and `exit_vec_valid_o` are 0, `exit_reason_o` is 0 and `vnmi_ready_o` is 1.
- R2: An NMI exits only when `nmi_exit_en_i` or `vnmi_en_i` is 1. An external interrupt exits only when `extint_exit_en_i` is 1. Otherwise the event has no effect.
- R3: With `vnmi_en_i`=1, an NMI exits with reason 3 even when `nmi_exit_en_i`=0.
- R4: INIT exits with reason 1 and SIPI exits with reason 2, whatever the control inputs are.
- R5: When several exiting events are present in the same cycle, the reason is the first present in this order: INIT (1), SIPI (2), NMI (3), external interrupt (4).
- R6: For an external-interrupt exit with `ack_on_exit_i`=1, `inta_req_o` rises in the cycle after the decision and stays high until `inta_ack_i` is sampled high. In the next cycle `exit_o` pulses with reason 4, `exit_vec_o` holds `inta_vec_i` as sampled with the acknowledge, and `exit_vec_valid_o` is 1. Events that arrive during the handshake are ignored.
- R7: For an external-interrupt exit with `ack_on_exit_i`=0, no acknowledge request is made, `exit_o` pulses with reason 4 in the cycle after the decision, and `exit_vec_valid_o` is 0.
- R8: `if_clear_o` pulses together with `exit_o` for every external-interrupt exit and for no other reason.
- R9: No exit is made while `guest_active_i` is 0. After an exit, no further exit is made until `guest_active_i` has been sampled at 0.
- R10: `vnmi_ready_o` is cleared by `vnmi_inject_i` and set by `vnmi_done_i`, with inject winning when both are present. Both take effect only while `vnmi_en_i`=1. While `vnmi_en_i`=0 the flag reads 1. NMI exits never change it.
- R11: `exit_o` lasts exactly one cycle, and `exit_reason_o` is 0 whenever `exit_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| guest_active_i | input | 1 | Guest context is running |
| init_i | input | 1 | INIT event request |
| sipi_i | input | 1 | SIPI event request |
| nmi_i | input | 1 | NMI event request |
| extint_i | input | 1 | External interrupt pending at the controller |
| nmi_exit_en_i | input | 1 | NMI causes an exit |
| extint_exit_en_i | input | 1 | External interrupt causes an exit |
| vnmi_en_i | input | 1 | Virtual-NMI mode |
| ack_on_exit_i | input | 1 | Acknowledge the interrupt controller on an external-interrupt exit |
| vnmi_inject_i | input | 1 | Monitor delivered a virtual NMI; guest not ready |
| vnmi_done_i | input | 1 | Guest finished its virtual-NMI handler; ready again |
| inta_req_o | output | 1 | Acknowledge request to the interrupt controller |
| inta_ack_i | input | 1 | Acknowledge from the interrupt controller |
| inta_vec_i | input | 8 | Vector returned with the acknowledge |
| exit_o | output | 1 | One-cycle exit strobe |
| exit_reason_o | output | 3 | Exit reason: 1 INIT, 2 SIPI, 3 NMI, 4 external interrupt |
| exit_vec_o | output | 8 | Captured interrupt vector |
| exit_vec_valid_o | output | 1 | Captured vector belongs to the latest exit |
| if_clear_o | output | 1 | Clear guest interrupt-enable flag |
| vnmi_ready_o | output | 1 | Guest ready for a virtual NMI |

## Verification
Two situations can put two functions into the same cycle. In the first, several event classes are raised together, so the priority pick runs alongside the exit-qualification rules; the bench drives all four at once and then strips the winners one by one. In the second, a higher-priority INIT arrives while an acknowledge handshake is still open, and it coincides with the acknowledge itself. Either the exit keeps reason 4 and the captured vector, or the INIT wrongly takes over. A behavioural model in the bench is stepped on every clock and compared against every output, and this comparison decides both cases.

// File: rtl/gexr_pkg.sv
package gexr_pkg;
  typedef enum logic [2:0] {
    RSN_NONE   = 3'd0,
    RSN_INIT   = 3'd1,
    RSN_SIPI   = 3'd2,
    RSN_NMI    = 3'd3,
    RSN_EXTINT = 3'd4
  } exit_rsn_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACK  = 2'd1,
    ST_HOST = 2'd2
  } ctrl_st_e;
endpackage

// File: rtl/gexr_select.sv
module gexr_select
  import gexr_pkg::*;
#(
  parameter int unsigned N_EVT = 4
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      init_i,
  input  logic      sipi_i,
  input  logic      nmi_i,
  input  logic      extint_i,
  input  logic      nmi_exit_en_i,
  input  logic      extint_exit_en_i,
  input  logic      vnmi_en_i,
  output logic      hit_o,
  output exit_rsn_e rsn_o
);
  // bit 0 is the highest priority; index+1 equals the reason code
  logic [N_EVT-1:0] qual;

  assign qual = {extint_i & extint_exit_en_i,
                 nmi_i & (nmi_exit_en_i | vnmi_en_i),
                 sipi_i,
                 init_i};

  always_comb begin
    rsn_o = RSN_NONE;
    for (int i = N_EVT - 1; i >= 0; i--) begin
      if (qual[i]) rsn_o = exit_rsn_e'(3'(i + 1));
    end
  end

  assign hit_o = |qual;

  p_init_first_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |-> (hit_o && rsn_o == RSN_INIT));
  p_nmi_gated_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_i && !nmi_exit_en_i && !vnmi_en_i && !init_i && !sipi_i && !extint_i) |-> !hit_o);
endmodule

// File: rtl/gexr_vnmi.sv
module gexr_vnmi (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic inject_i,
  input  logic done_i,
  output logic ready_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ready_o <= 1'b1;
    else if (!en_i)    ready_o <= 1'b1;
    else if (inject_i) ready_o <= 1'b0;
    else if (done_i)   ready_o <= 1'b1;
  end

  p_fall_by_inject_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_o) |-> $past(inject_i && en_i));
  p_rise_by_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(done_i || !en_i));
endmodule

// File: rtl/gexr_ctrl.sv
module gexr_ctrl
  import gexr_pkg::*;
#(
  parameter int unsigned VEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             guest_active_i,
  input  logic             hit_i,
  input  exit_rsn_e        rsn_i,
  input  logic             ack_on_exit_i,
  output logic             inta_req_o,
  input  logic             inta_ack_i,
  input  logic [VEC_W-1:0] inta_vec_i,
  output logic             exit_o,
  output exit_rsn_e        exit_rsn_o,
  output logic [VEC_W-1:0] exit_vec_o,
  output logic             exit_vec_valid_o,
  output logic             if_clear_o
);
  ctrl_st_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q             <= ST_IDLE;
      inta_req_o       <= 1'b0;
      exit_o           <= 1'b0;
      exit_rsn_o       <= RSN_NONE;
      exit_vec_o       <= '0;
      exit_vec_valid_o <= 1'b0;
      if_clear_o       <= 1'b0;
    end else begin
      exit_o     <= 1'b0;
      exit_rsn_o <= RSN_NONE;
      if_clear_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (guest_active_i && hit_i) begin
          if (rsn_i == RSN_EXTINT && ack_on_exit_i) begin
            st_q       <= ST_ACK;
            inta_req_o <= 1'b1;
          end else begin
            st_q             <= ST_HOST;
            exit_o           <= 1'b1;
            exit_rsn_o       <= rsn_i;
            exit_vec_valid_o <= 1'b0;
            if_clear_o       <= (rsn_i == RSN_EXTINT);
          end
        end
        ST_ACK: if (inta_ack_i) begin
          st_q             <= ST_HOST;
          inta_req_o       <= 1'b0;
          exit_o           <= 1'b1;
          exit_rsn_o       <= RSN_EXTINT;
          exit_vec_o       <= inta_vec_i;
          exit_vec_valid_o <= 1'b1;
          if_clear_o       <= 1'b1;
        end
        ST_HOST: if (!guest_active_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  p_exit_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_o |=> !exit_o);
  p_rsn_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exit_o |-> exit_rsn_o == RSN_NONE);
  p_req_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_req_o && !inta_ack_i) |=> inta_req_o);
  p_exit_after_ack_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_req_o && inta_ack_i) |=> (exit_o && exit_rsn_o == RSN_EXTINT && exit_vec_valid_o));
  p_ifclr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    if_clear_o |-> (exit_o && exit_rsn_o == RSN_EXTINT));
  p_no_exit_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !guest_active_i) |=> !exit_o && !inta_req_o);
endmodule

// File: rtl/guest_exit_router.sv
module guest_exit_router
  import gexr_pkg::*;
#(
  parameter int unsigned VEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             guest_active_i,
  input  logic             init_i,
  input  logic             sipi_i,
  input  logic             nmi_i,
  input  logic             extint_i,
  input  logic             nmi_exit_en_i,
  input  logic             extint_exit_en_i,
  input  logic             vnmi_en_i,
  input  logic             ack_on_exit_i,
  input  logic             vnmi_inject_i,
  input  logic             vnmi_done_i,
  output logic             inta_req_o,
  input  logic             inta_ack_i,
  input  logic [VEC_W-1:0] inta_vec_i,
  output logic             exit_o,
  output logic [2:0]       exit_reason_o,
  output logic [VEC_W-1:0] exit_vec_o,
  output logic             exit_vec_valid_o,
  output logic             if_clear_o,
  output logic             vnmi_ready_o
);
  logic      sel_hit;
  exit_rsn_e sel_rsn;
  exit_rsn_e exit_rsn;

  gexr_select u_select (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .init_i           (init_i),
    .sipi_i           (sipi_i),
    .nmi_i            (nmi_i),
    .extint_i         (extint_i),
    .nmi_exit_en_i    (nmi_exit_en_i),
    .extint_exit_en_i (extint_exit_en_i),
    .vnmi_en_i        (vnmi_en_i),
    .hit_o            (sel_hit),
    .rsn_o            (sel_rsn)
  );

  gexr_ctrl #(.VEC_W(VEC_W)) u_ctrl (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .guest_active_i   (guest_active_i),
    .hit_i            (sel_hit),
    .rsn_i            (sel_rsn),
    .ack_on_exit_i    (ack_on_exit_i),
    .inta_req_o       (inta_req_o),
    .inta_ack_i       (inta_ack_i),
    .inta_vec_i       (inta_vec_i),
    .exit_o           (exit_o),
    .exit_rsn_o       (exit_rsn),
    .exit_vec_o       (exit_vec_o),
    .exit_vec_valid_o (exit_vec_valid_o),
    .if_clear_o       (if_clear_o)
  );

  gexr_vnmi u_vnmi (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (vnmi_en_i),
    .inject_i (vnmi_inject_i),
    .done_i   (vnmi_done_i),
    .ready_o  (vnmi_ready_o)
  );

  assign exit_reason_o = exit_rsn;
endmodule

// File: tb/guest_exit_router_tb.sv
module guest_exit_router_tb;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic guest_active_i = 0, init_i = 0, sipi_i = 0, nmi_i = 0, extint_i = 0;
  logic nmi_exit_en_i = 0, extint_exit_en_i = 0, vnmi_en_i = 0, ack_on_exit_i = 0;
  logic vnmi_inject_i = 0, vnmi_done_i = 0, inta_ack_i = 0;
  logic [7:0] inta_vec_i = 8'h00;
  logic inta_req_o, exit_o, exit_vec_valid_o, if_clear_o, vnmi_ready_o;
  logic [2:0] exit_reason_o;
  logic [7:0] exit_vec_o;

  int checks = 0, fails = 0;
  bit finished = 0;

  guest_exit_router u_dut (.*);

  always #10 clk_i = ~clk_i;

  // behavioural reference: mode 0 waiting for event, 1 acknowledge pending, 2 exited
  int m_mode, m_exit, m_rsn, m_req, m_vec, m_val, m_ifc, m_rdy;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_mode = 0; m_exit = 0; m_rsn = 0; m_req = 0; m_vec = 0; m_val = 0; m_ifc = 0; m_rdy = 1;
    end else begin
      int code;
      m_exit = 0; m_rsn = 0; m_ifc = 0;
      code = 0;
      if (init_i) code = 1;
      else if (sipi_i) code = 2;
      else if (nmi_i && (nmi_exit_en_i || vnmi_en_i)) code = 3;
      else if (extint_i && extint_exit_en_i) code = 4;
      if (m_mode == 0) begin
        if (guest_active_i && code != 0) begin
          if (code == 4 && ack_on_exit_i) begin m_mode = 1; m_req = 1; end
          else begin
            m_mode = 2; m_exit = 1; m_rsn = code; m_val = 0; m_ifc = (code == 4);
          end
        end
      end else if (m_mode == 1) begin
        if (inta_ack_i) begin
          m_mode = 2; m_req = 0; m_exit = 1; m_rsn = 4; m_vec = inta_vec_i; m_val = 1; m_ifc = 1;
        end
      end else if (!guest_active_i) m_mode = 0;
      if (!vnmi_en_i) m_rdy = 1;
      else if (vnmi_inject_i) m_rdy = 0;
      else if (vnmi_done_i) m_rdy = 1;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle compare plus observed-event bookkeeping
  int n_exit, n_req, n_ifc, last_rsn, last_vec, last_val;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      chk("R11 exit_o", exit_o, m_exit);
      chk("R5 exit_reason_o", exit_reason_o, m_rsn);
      chk("R6 inta_req_o", inta_req_o, m_req);
      chk("R6 exit_vec_o", exit_vec_o, m_vec);
      chk("R7 exit_vec_valid_o", exit_vec_valid_o, m_val);
      chk("R8 if_clear_o", if_clear_o, m_ifc);
      chk("R10 vnmi_ready_o", vnmi_ready_o, m_rdy);
      if (inta_req_o) n_req++;
      if (if_clear_o) n_ifc++;
      if (exit_o) begin
        n_exit++; last_rsn = exit_reason_o; last_vec = exit_vec_o; last_val = exit_vec_valid_o;
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk_i);
    #1;
  endtask

  task automatic clr_obs();
    n_exit = 0; n_req = 0; n_ifc = 0; last_rsn = 0; last_vec = 0; last_val = 0;
  endtask

  task automatic end_run();
    init_i = 0; sipi_i = 0; nmi_i = 0; extint_i = 0; guest_active_i = 0;
    step(2);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 20000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    clr_obs();
    step(2);
    // R1: reset values
    chk("R1 exit_o", exit_o, 0);
    chk("R1 inta_req_o", inta_req_o, 0);
    chk("R1 if_clear_o", if_clear_o, 0);
    chk("R1 exit_vec_valid_o", exit_vec_valid_o, 0);
    chk("R1 exit_reason_o", exit_reason_o, 0);
    chk("R1 vnmi_ready_o", vnmi_ready_o, 1);
    rst_ni = 1;
    step(1);

    // R2: NMI without control has no effect, then exits
    clr_obs(); guest_active_i = 1; nmi_i = 1; step(4);
    chk("R2 nmi ignored", n_exit, 0);
    nmi_exit_en_i = 1; step(3);
    chk("R2 nmi exit count", n_exit, 1);
    chk("R2 nmi reason", last_rsn, 3);
    end_run(); nmi_exit_en_i = 0;

    // R2: external interrupt without control has no effect
    clr_obs(); guest_active_i = 1; extint_i = 1; step(4);
    chk("R2 extint ignored", n_exit, 0);
    end_run();

    // R3: virtual-NMI mode forces exit
    clr_obs(); vnmi_en_i = 1; guest_active_i = 1; nmi_i = 1; step(3);
    chk("R3 vnmi exit", n_exit, 1);
    chk("R3 vnmi reason", last_rsn, 3);
    end_run(); vnmi_en_i = 0;

    // R4: INIT and SIPI with all controls off
    clr_obs(); guest_active_i = 1; init_i = 1; step(3);
    chk("R4 init reason", last_rsn, 1);
    end_run();
    clr_obs(); guest_active_i = 1; sipi_i = 1; step(3);
    chk("R4 sipi reason", last_rsn, 2);
    end_run();

    // R5: priority with simultaneous events
    nmi_exit_en_i = 1; extint_exit_en_i = 1;
    clr_obs(); guest_active_i = 1; init_i = 1; sipi_i = 1; nmi_i = 1; extint_i = 1; step(3);
    chk("R5 all four", last_rsn, 1); end_run();
    clr_obs(); guest_active_i = 1; sipi_i = 1; nmi_i = 1; extint_i = 1; step(3);
    chk("R5 sipi over nmi", last_rsn, 2); end_run();
    clr_obs(); guest_active_i = 1; nmi_i = 1; extint_i = 1; step(3);
    chk("R5 nmi over extint", last_rsn, 3);
    chk("R8 no clear on nmi", n_ifc, 0); end_run();

    // R7 / R8: external interrupt without acknowledge
    clr_obs(); guest_active_i = 1; extint_i = 1; step(3);
    chk("R7 reason", last_rsn, 4);
    chk("R7 no req", n_req, 0);
    chk("R7 valid low", last_val, 0);
    chk("R8 if clear", n_ifc, 1);
    end_run();

    // R6: acknowledge handshake, INIT collides with the acknowledge
    ack_on_exit_i = 1;
    clr_obs(); guest_active_i = 1; extint_i = 1; step(1);
    chk("R6 no early exit", n_exit, 0);
    step(3);
    chk("R6 req held", inta_req_o, 1);
    init_i = 1; inta_ack_i = 1; inta_vec_i = 8'hA5; step(1);
    inta_ack_i = 0; inta_vec_i = 8'h00; step(2);
    chk("R6 exit count", n_exit, 1);
    chk("R6 reason", last_rsn, 4);
    chk("R6 vector", last_vec, 8'hA5);
    chk("R6 valid", last_val, 1);
    chk("R6 req dropped", inta_req_o, 0);
    end_run(); ack_on_exit_i = 0;

    // R9: single exit per run, none while inactive
    clr_obs(); guest_active_i = 1; nmi_i = 1; step(8);
    chk("R9 one exit", n_exit, 1);
    guest_active_i = 0; init_i = 1; step(4);
    chk("R9 inactive", n_exit, 1);
    guest_active_i = 1; step(3);
    chk("R9 re-armed", n_exit, 2);
    end_run();

    // R10: readiness flag
    vnmi_en_i = 1; vnmi_inject_i = 1; step(1); vnmi_inject_i = 0; step(1);
    chk("R10 inject clears", vnmi_ready_o, 0);
    clr_obs(); guest_active_i = 1; nmi_i = 1; step(3);
    chk("R10 nmi exit keeps flag", vnmi_ready_o, 0);
    end_run();
    vnmi_inject_i = 1; vnmi_done_i = 1; step(2); vnmi_done_i = 0; vnmi_inject_i = 0;
    chk("R10 inject wins", vnmi_ready_o, 0);
    vnmi_done_i = 1; step(1); vnmi_done_i = 0; step(1);
    chk("R10 done sets", vnmi_ready_o, 1);
    vnmi_en_i = 0; vnmi_inject_i = 1; step(2); vnmi_inject_i = 0;
    chk("R10 disabled holds", vnmi_ready_o, 1);

    step(2);
    finish_run();
  end
endmodule